// File: doc/BRIEF.md
# Dual-Direction Prioritised Bus Arbiter

This block decides which of several masters owns a shared on-chip bus. Read and write traffic have separate data paths, so the arbiter runs two independent channels: one read tenure and one write tenure can be in progress at the same time, usually for different masters. A master presents a request, a direction bit, a transfer kind (single, counted burst or open-ended burst), a 4-bit length and a lock flag. Each master also has a 2-bit priority value on a configuration input.

Each channel is a small state machine. Its states are PARK, XFER and HOLD:

- **PARK**: no tenure is active and the grant rests on the last owner.
- **XFER**: a tenure is running and the slave's data acknowledges are counted.
- **HOLD**: a locked owner has finished a tenure but keeps ownership.

The transitions are:

- **START**: PARK to XFER.
- **NEXT**: XFER to XFER, an overlapped handoff.
- **DONE**: XFER to PARK.
- **KEEP**: XFER to HOLD, at the end of a locked tenure.
- **RESUME**: HOLD to XFER.
- **RELEASE**: HOLD to PARK.

Arbitration runs every cycle. In the cycle of the last acknowledge it chooses the next owner, so the new grant appears on the same edge that retires the old tenure.

Top module: `busarb_top`

## Requirements
- R1: During and right after reset, both channels report busy low and a one-hot grant on master 0.
- R2: When a channel is parked, the eligible requester with the largest 2-bit priority value wins. Its grant and busy appear one clock after the request is first sampled.
- R3: Ties between equal priorities are broken round-robin. The scan starts at the master just after the previous winner of that channel, and master 0 comes first after reset.
- R4: Transfer kind code 1 is a counted burst that lasts L+1 acknowledges, where L is the 4-bit length field. Code 0 (single) and code 3 end on the first acknowledge whatever the length.
- R5: Kind code 2 is an open-ended burst. It ends on the acknowledge during which the owner's burst flag is low.
- R6: When the final acknowledge is taken and another master requests that channel, the new owner is granted with busy high in the very next cycle, with no idle cycle. The finishing owner is not a candidate in that cycle.
- R7: Lock is sampled at grant time. While it is held, no other master is granted on that channel. After the final beat, ownership stays with the holder (busy low), and its next request resumes at once. Ownership is released only once the holder drops both lock and request.
- R8: With no eligible request, busy stays low and the grant stays on the last owner.
- R9: A request with the direction bit set to 1 is served by the read channel, and 0 by the write channel. Both channels can be busy together.
- R10: Acknowledges that arrive while a channel is not busy have no effect, and are not counted toward a later burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | N | Per-master request |
| rnw_i | input | N | Per-master direction, 1 = read |
| kind_i | input | 2*N | Per-master transfer kind code |
| len_i | input | 4*N | Per-master counted-burst length L |
| burst_i | input | N | Per-master open-burst continue flag |
| lock_i | input | N | Per-master lock flag |
| prio_i | input | 2*N | Per-master priority value |
| rd_ack_i | input | 1 | Read data acknowledge |
| wr_ack_i | input | 1 | Write data acknowledge |
| rd_gnt_o | output | N | One-hot read owner |
| rd_busy_o | output | 1 | Read tenure active |
| wr_gnt_o | output | N | One-hot write owner |
| wr_busy_o | output | 1 | Write tenure active |

## Verification
The write channel is swept over all 256 priority settings, each combined with all 15 non-empty request masks. Each result is compared against an arithmetic model of the winner that carries the round-robin pointer from one trial to the next, so priority order and tie rotation are told apart across every combination. Counted bursts are run at all sixteen lengths to expose off-by-one beat counting. Open-ended bursts, overlapped handoff, lock hold and release, and spurious acknowledges while idle are run as directed sequences. Together they separate an idle gap from a true back-to-back handoff, and a held lock from a parked grant. A concurrent read and write request shows that the two channels do not interfere.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    typedef enum logic [1:0] {
        XK_SINGLE = 2'd0,
        XK_FIXED  = 2'd1,
        XK_OPEN   = 2'd2,
        XK_RSVD   = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_PARK = 2'd0,
        ST_XFER = 2'd1,
        ST_HOLD = 2'd2
    } chan_state_e;

endpackage

// File: rtl/busarb_pick.sv
module busarb_pick #(
    parameter int N  = 4,
    parameter int PW = 2,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]    elig_i,
    input  logic [N*PW-1:0] prio_i,
    input  logic [IW-1:0]   rr_i,
    output logic            found_o,
    output logic [IW-1:0]   winner_o
);

    // Scan starts just after the last winner; strict '>' keeps the
    // first-found master among equals, which gives the rotation.
    always_comb begin
        logic [PW-1:0] best;
        int idx;
        found_o  = 1'b0;
        winner_o = '0;
        best     = '0;
        idx      = 0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(rr_i) + k) % N;
            if (elig_i[idx] && (!found_o || prio_i[idx*PW +: PW] > best)) begin
                found_o  = 1'b1;
                winner_o = IW'(idx);
                best     = prio_i[idx*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/busarb_chan.sv
module busarb_chan
    import busarb_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 2,
    parameter int LW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    chan_req_i,
    input  logic [N*2-1:0]  kind_i,
    input  logic [N*LW-1:0] len_i,
    input  logic [N-1:0]    burst_i,
    input  logic [N-1:0]    lock_i,
    input  logic [N*PW-1:0] prio_i,
    input  logic            ack_i,
    output logic [N-1:0]    gnt_o,
    output logic            busy_o
);

    chan_state_e   state_q, state_d;
    logic [IW-1:0] owner_q;
    logic [IW-1:0] rr_q;
    xfer_kind_e    kind_q;
    logic [LW-1:0] left_q;
    logic          lock_q;

    logic [N-1:0]  own_mask;
    logic [N-1:0]  elig;
    logic          found;
    logic [IW-1:0] winner;
    logic          last_beat;
    logic          take;

    assign own_mask = {{(N-1){1'b0}}, 1'b1} << owner_q;

    // Candidate set depends on the state: a held lock admits only the
    // holder; a finishing owner is left out of its own handoff.
    always_comb begin
        unique case (state_q)
            ST_PARK: elig = chan_req_i;
            ST_XFER: elig = lock_q ? '0 : (chan_req_i & ~own_mask);
            ST_HOLD: elig = chan_req_i & own_mask;
            default: elig = '0;
        endcase
    end

    busarb_pick #(.N(N), .PW(PW)) pick_i (
        .elig_i  (elig),
        .prio_i  (prio_i),
        .rr_i    (rr_q),
        .found_o (found),
        .winner_o(winner)
    );

    always_comb begin
        last_beat = 1'b0;
        if (state_q == ST_XFER && ack_i) begin
            unique case (kind_q)
                XK_FIXED: last_beat = (left_q == '0);
                XK_OPEN:  last_beat = !burst_i[owner_q];
                default:  last_beat = 1'b1;
            endcase
        end
    end

    // Next-state and take decision
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_PARK: begin
                if (found) begin
                    take    = 1'b1;
                    state_d = ST_XFER;                      // START
                end
            end
            ST_XFER: begin
                if (last_beat) begin
                    if (lock_q) begin
                        state_d = ST_HOLD;                  // KEEP
                    end else if (found) begin
                        take    = 1'b1;
                        state_d = ST_XFER;                  // NEXT
                    end else begin
                        state_d = ST_PARK;                  // DONE
                    end
                end
            end
            ST_HOLD: begin
                if (found) begin
                    take    = 1'b1;
                    state_d = ST_XFER;                      // RESUME
                end else if (!chan_req_i[owner_q] && !lock_i[owner_q]) begin
                    state_d = ST_PARK;                      // RELEASE
                end
            end
            default: state_d = ST_PARK;
        endcase
    end

    // State register and tenure context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
            owner_q <= '0;
            rr_q    <= IW'(N - 1);
            kind_q  <= XK_SINGLE;
            left_q  <= '0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                owner_q <= winner;
                rr_q    <= winner;
                kind_q  <= xfer_kind_e'(kind_i[winner*2 +: 2]);
                left_q  <= len_i[winner*LW +: LW];
                lock_q  <= lock_i[winner];
            end else if (state_q == ST_XFER && ack_i && !last_beat && kind_q == XK_FIXED) begin
                left_q <= left_q - 1'b1;
            end else if (state_q == ST_HOLD && state_d == ST_PARK) begin
                lock_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        gnt_o  = own_mask;
        busy_o = (state_q == ST_XFER);
    end

    a_r4_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ack_i && kind_q == XK_FIXED && left_q != '0) |=> (busy_o && $stable(gnt_o)));

    a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !lock_q && |(chan_req_i & ~gnt_o)) |=> (busy_o && gnt_o != $past(gnt_o)));

    a_r7_lock_keeps_owner: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(gnt_o));

    a_r8_parked_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK && chan_req_i == '0) |=> (!busy_o && $stable(gnt_o)));

    a_r10_idle_ack_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && ack_i && chan_req_i == '0 && state_q != ST_HOLD) |=> !busy_o);

endmodule

// File: rtl/busarb_top.sv
module busarb_top #(
    parameter int N  = 4,
    parameter int PW = 2,
    parameter int LW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_i,
    input  logic [N-1:0]    rnw_i,
    input  logic [N*2-1:0]  kind_i,
    input  logic [N*LW-1:0] len_i,
    input  logic [N-1:0]    burst_i,
    input  logic [N-1:0]    lock_i,
    input  logic [N*PW-1:0] prio_i,
    input  logic            rd_ack_i,
    input  logic            wr_ack_i,
    output logic [N-1:0]    rd_gnt_o,
    output logic            rd_busy_o,
    output logic [N-1:0]    wr_gnt_o,
    output logic            wr_busy_o
);

    localparam int NCH = 2;   // index 0 = read, 1 = write

    logic [N-1:0] gnt_w  [NCH];
    logic         busy_w [NCH];
    logic [NCH-1:0] ack_w;

    assign ack_w = {wr_ack_i, rd_ack_i};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [N-1:0] chan_req;
        assign chan_req = (ch == 0) ? (req_i & rnw_i) : (req_i & ~rnw_i);

        busarb_chan #(.N(N), .PW(PW), .LW(LW)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .chan_req_i(chan_req),
            .kind_i    (kind_i),
            .len_i     (len_i),
            .burst_i   (burst_i),
            .lock_i    (lock_i),
            .prio_i    (prio_i),
            .ack_i     (ack_w[ch]),
            .gnt_o     (gnt_w[ch]),
            .busy_o    (busy_w[ch])
        );
    end

    assign rd_gnt_o  = gnt_w[0];
    assign rd_busy_o = busy_w[0];
    assign wr_gnt_o  = gnt_w[1];
    assign wr_busy_o = busy_w[1];

    a_r9_direction_split: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_busy_o && (req_i & ~rnw_i) != '0 && (req_i & rnw_i) == '0
         && rd_gnt_o == $past(rd_gnt_o)) |=> !rd_busy_o);

endmodule

// File: tb/busarb_top_tb_top.sv
module busarb_top_tb_top;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0, rnw = '0, burst = '0, lock = '0;
    logic [7:0]  kind = '0, prio = '0;
    logic [15:0] len = '0;
    logic        rd_ack = 1'b0, wr_ack = 1'b0;
    logic [3:0]  rd_gnt, wr_gnt;
    logic        rd_busy, wr_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    busarb_top #(.N(N), .PW(2), .LW(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .rnw_i(rnw), .kind_i(kind),
        .len_i(len), .burst_i(burst), .lock_i(lock), .prio_i(prio),
        .rd_ack_i(rd_ack), .wr_ack_i(wr_ack),
        .rd_gnt_o(rd_gnt), .rd_busy_o(rd_busy),
        .wr_gnt_o(wr_gnt), .wr_busy_o(wr_busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int model_pick(input logic [3:0] m, input logic [7:0] p, input int rr);
        int w = -1;
        int bp = -1;
        for (int k = 1; k <= 4; k++) begin
            int idx = (rr + k) % 4;
            if (m[idx] && int'(p[idx*2 +: 2]) > bp) begin
                w  = idx;
                bp = int'(p[idx*2 +: 2]);
            end
        end
        return w;
    endfunction

    initial begin
        int rr;
        rr = 3;
        // R1 reset state
        tick();
        check("R1 rd_busy", 32'(rd_busy), 0);
        check("R1 rd_gnt", 32'(rd_gnt), 1);
        check("R1 wr_busy", 32'(wr_busy), 0);
        check("R1 wr_gnt", 32'(wr_gnt), 1);
        rst_n = 1'b1;
        tick();
        check("R1 wr_gnt after reset", 32'(wr_gnt), 1);

        // R2 R3 R8 sweep on the write channel: priorities x request masks
        for (int p = 0; p < 256; p++) begin
            for (int m = 1; m < 16; m++) begin
                int w;
                prio = 8'(p);
                req  = 4'(m);
                rnw  = '0;
                kind = '0;
                w = model_pick(4'(m), 8'(p), rr);
                tick();
                check("R2 R3 grant winner", 32'(wr_gnt), 32'(1) << w);
                check("R2 busy after grant", 32'(wr_busy), 1);
                req = '0;
                wr_ack = 1'b1;
                tick();
                wr_ack = 1'b0;
                check("R8 parked busy", 32'(wr_busy), 0);
                check("R8 parked grant", 32'(wr_gnt), 32'(1) << w);
                rr = w;
            end
        end

        // R4 counted bursts on the read channel, master 1
        prio = '0;
        for (int L = 0; L < 16; L++) begin
            req = 4'b0010; rnw = 4'b0010;
            kind = 8'b0000_0100; len = 16'(L) << 4;
            tick();
            check("R4 fixed start busy", 32'(rd_busy), 1);
            check("R4 fixed start gnt", 32'(rd_gnt), 32'h2);
            req = '0; rd_ack = 1'b1;
            for (int b = 1; b <= L + 1; b++) begin
                tick();
                check("R4 fixed beat busy", 32'(rd_busy), (b < L + 1) ? 1 : 0);
            end
            rd_ack = 1'b0;
        end
        // R4 single and code 3 end after one ack
        for (int c = 0; c < 4; c += 3) begin
            req = 4'b0010; rnw = 4'b0010;
            kind = 8'(c) << 2; len = 16'h0050;
            tick();
            check("R4 short start", 32'(rd_busy), 1);
            req = '0; rd_ack = 1'b1;
            tick();
            rd_ack = 1'b0;
            check("R4 short end", 32'(rd_busy), 0);
        end

        // R5 open burst, master 2 read
        req = 4'b0100; rnw = 4'b0100; kind = 8'b0010_0000; burst = 4'b0100;
        tick();
        check("R5 open start", 32'(rd_gnt), 32'h4);
        req = '0; rd_ack = 1'b1;
        for (int b = 0; b < 3; b++) begin
            tick();
            check("R5 open continues", 32'(rd_busy), 1);
        end
        burst = '0;
        tick();
        rd_ack = 1'b0;
        check("R5 open ends", 32'(rd_busy), 0);

        // R6 overlapped handoff on write
        rnw = '0; kind = '0; len = '0;
        prio = 8'b0001_0011;           // m0 = 3, m2 = 1
        req = 4'b0101;
        tick();
        check("R6 first owner", 32'(wr_gnt), 32'h1);
        req = 4'b0100; wr_ack = 1'b1;
        tick();
        check("R6 handoff gnt", 32'(wr_gnt), 32'h4);
        check("R6 handoff no gap", 32'(wr_busy), 1);
        req = '0;
        tick();
        wr_ack = 1'b0;
        check("R6 then park", 32'(wr_busy), 0);

        // R7 lock hold and release on write
        prio = 8'b1100_0000;           // m3 = 3, m1 = 0
        req = 4'b0010; lock = 4'b0010;
        tick();
        check("R7 locker granted", 32'(wr_gnt), 32'h2);
        req = 4'b1000; wr_ack = 1'b1;
        tick();
        wr_ack = 1'b0;
        check("R7 hold busy", 32'(wr_busy), 0);
        check("R7 hold gnt", 32'(wr_gnt), 32'h2);
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R7 hold blocks other", 32'(wr_gnt), 32'h2);
        end
        req = 4'b1010;
        tick();
        check("R7 resume busy", 32'(wr_busy), 1);
        check("R7 resume gnt", 32'(wr_gnt), 32'h2);
        req = 4'b1000; wr_ack = 1'b1;
        tick();
        wr_ack = 1'b0; lock = '0;
        check("R7 hold again", 32'(wr_gnt), 32'h2);
        tick();
        check("R7 released not busy", 32'(wr_busy), 0);
        tick();
        check("R7 other granted", 32'(wr_gnt), 32'h8);
        check("R7 other busy", 32'(wr_busy), 1);
        req = '0; wr_ack = 1'b1;
        tick();
        wr_ack = 1'b0;

        // R9 concurrent read and write
        prio = '0;
        req = 4'b1001; rnw = 4'b0001;
        tick();
        check("R9 rd gnt", 32'(rd_gnt), 32'h1);
        check("R9 rd busy", 32'(rd_busy), 1);
        check("R9 wr gnt", 32'(wr_gnt), 32'h8);
        check("R9 wr busy", 32'(wr_busy), 1);
        req = '0; rd_ack = 1'b1; wr_ack = 1'b1;
        tick();
        rd_ack = 1'b0; wr_ack = 1'b0;
        check("R9 both done", 32'({rd_busy, wr_busy}), 0);

        // R10 acks while idle are ignored
        rd_ack = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R10 idle busy", 32'(rd_busy), 0);
            check("R10 idle gnt", 32'(rd_gnt), 32'h1);
        end
        req = 4'b0100; rnw = 4'b0100; kind = 8'b0001_0000; len = 16'h0100;
        tick();
        req = '0;
        check("R10 start busy", 32'(rd_busy), 1);
        tick();
        check("R10 first beat", 32'(rd_busy), 1);
        tick();
        check("R10 second beat ends", 32'(rd_busy), 0);
        rd_ack = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule